// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of an Ethernet receive path. It decides whether a frame should be kept by looking only at its six destination address bytes. The bytes arrive one at a time, with `da_first` marking the first one. In the cycle after the sixth byte is taken, the block raises a one-cycle result pulse that carries an accept or reject flag. Gaps between bytes are allowed. A new `da_first` abandons a partly received address and starts again.

The filter is steered by a 16-bit receive control word, a 6-byte station address and a 64-bin multicast hash table. All three sit behind a small halfword register port and can be read back. The hash bin of a group address is computed on the fly. It is the top six bits of the Ethernet CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, least-significant bit first, no final inversion), taken over the six address bytes in arrival order.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, the control word reads 0x0188, and the station address and hash table read as zero. No result pulse appears until an address has been received.
- R2: The register port uses these addresses: 0 is the control word. 1, 2 and 3 hold station bytes {1,0}, {3,2} and {5,4}, with the lower-numbered byte in bits 7:0. 4 to 7 hold hash table bytes {1,0}, {3,2}, {5,4} and {7,6}. Read data appears one cycle after the address. Addresses 8 to 15 read as zero, and writes to them change nothing.
- R3: `res_valid` pulses for exactly one cycle, in the cycle after the sixth address byte is taken. Idle cycles between bytes are allowed. A byte with `da_first` restarts the count. Bytes after the sixth are ignored until the next `da_first`.
- R4: When control bit 0 (promiscuous) is set, every address is accepted.
- R5: An address equal to the station address is accepted whatever the control word holds. Station byte 0 is compared with the first byte received.
- R6: The all-ones address is accepted only when control bit 3 is set, unless R4 or R5 applies.
- R7: Any other address whose first byte has bit 0 set is a group address. It is accepted when control bit 1 (all groups) is set.
- R8: When control bit 4 is set, a group address is also accepted if the hash table holds a 1 for its bin. The bin is CRC bits 31:26, the table byte is bin>>3 and the bit within that byte is bin&7.
- R9: An individual address other than the station address is rejected unless R4 applies.
- R10: Control bits other than 0, 1, 3 and 4 have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address for both write and read |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data for the previous cycle's address |
| da_valid | input | 1 | Destination address byte present |
| da_first | input | 1 | Marks the first address byte of a frame |
| da_byte | input | 8 | Destination address byte |
| res_valid | output | 1 | One-cycle pulse carrying the frame decision |
| res_accept | output | 1 | Decision: 1 accept, 0 reject; valid with res_valid |

## Verification
The embedded assertions check several rules on every cycle:
- promiscuous mode and a station-address match force an accept;
- a broadcast with its enable clear, and a foreign individual address, force a reject;
- the result is never high on two cycles in a row;
- the byte counter stays in range and ignores stray bytes;
- writes to the control word land, and unmapped reads return zero.

The correctness of the CRC-derived hash bin, the byte and bit placement in the table, and the halfword register layout can only be shown by the bench. It runs many group addresses against tables it chooses, and compares every cycle with its own behavioural model. Restart in the middle of an address and inter-byte gaps are also covered only by the bench scenarios.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int          CTL_W      = 16;
  localparam logic [15:0] CTL_RESET  = 16'h0188;
  localparam int          CTL_PROMISC = 0;
  localparam int          CTL_ALLGRP  = 1;
  localparam int          CTL_BCAST   = 3;
  localparam int          CTL_HASHGRP = 4;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;

  // decision-relevant control bits, gathered by the register block
  typedef struct packed {
    logic hash_grp;
    logic bcast;
    logic all_grp;
    logic promisc;
  } rxf_mode_t;

  // one byte of reflected CRC-32, least-significant bit first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int CFG_AW     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [15:0]             cfg_wdata,
  output logic [15:0]             cfg_rdata,
  output rxf_mode_t               mode,
  output logic [8*ADDR_BYTES-1:0] mac_flat,
  output logic [(1<<HASH_BITS)-1:0] hash_flat
);
  localparam int MAC_HW    = ADDR_BYTES / 2;
  localparam int TBL       = 1 << HASH_BITS;
  localparam int HASH_HW   = TBL / 16;
  localparam int HASH_BASE = 1 + MAC_HW;
  localparam int NREG      = HASH_BASE + HASH_HW;

  logic [15:0] ctl_q;
  logic [15:0] mac_q  [MAC_HW];
  logic [15:0] hash_q [HASH_HW];
  logic [15:0] rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET;
      for (int i = 0; i < MAC_HW; i++)  mac_q[i]  <= '0;
      for (int j = 0; j < HASH_HW; j++) hash_q[j] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == '0) ctl_q <= cfg_wdata;
      for (int i = 0; i < MAC_HW; i++)
        if (cfg_addr == CFG_AW'(1 + i)) mac_q[i] <= cfg_wdata;
      for (int j = 0; j < HASH_HW; j++)
        if (cfg_addr == CFG_AW'(HASH_BASE + j)) hash_q[j] <= cfg_wdata;
    end
  end

  always_comb begin
    rd_n = '0;
    if (cfg_addr == '0) rd_n = ctl_q;
    for (int i = 0; i < MAC_HW; i++)
      if (cfg_addr == CFG_AW'(1 + i)) rd_n = mac_q[i];
    for (int j = 0; j < HASH_HW; j++)
      if (cfg_addr == CFG_AW'(HASH_BASE + j)) rd_n = hash_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_n;
  end

  generate
    for (genvar g = 0; g < MAC_HW; g++) begin : g_mac
      assign mac_flat[16*g +: 16] = mac_q[g];
    end
    for (genvar h = 0; h < HASH_HW; h++) begin : g_hash
      assign hash_flat[16*h +: 16] = hash_q[h];
    end
  endgenerate

  assign mode.promisc  = ctl_q[CTL_PROMISC];
  assign mode.all_grp  = ctl_q[CTL_ALLGRP];
  assign mode.bcast    = ctl_q[CTL_BCAST];
  assign mode.hash_grp = ctl_q[CTL_HASHGRP];

  // R1: control word comes out of reset at its default
  p_ctl_reset_r1: assert property (@(posedge clk) rst |=> (mode == rxf_mode_t'(4'b0100)) && (cfg_rdata == '0));

  // R2: a control write is visible through read-back of address 0
  p_ctl_write_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == '0) |=> (mode.promisc == $past(cfg_wdata[CTL_PROMISC])) && (mode.bcast == $past(cfg_wdata[CTL_BCAST])));

  // R2: unmapped addresses read zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(cfg_addr) >= NREG) |=> (cfg_rdata == '0));

endmodule

// File: rtl/rxf_addr_track.sv
module rxf_addr_track
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    da_valid,
  input  logic                    da_first,
  input  logic [7:0]              da_byte,
  input  logic [8*ADDR_BYTES-1:0] mac_flat,
  output logic                    fire,
  output logic                    sta_hit,
  output logic                    bcast,
  output logic                    grp,
  output logic [HASH_BITS-1:0]    bin
);
  localparam int            IW   = $clog2(ADDR_BYTES + 1);
  localparam logic [IW-1:0] IDLE = IW'(ADDR_BYTES);
  localparam logic [IW-1:0] LAST = IW'(ADDR_BYTES - 1);

  logic [IW-1:0] idx_q, cur_idx;
  logic [31:0]   crc_q, crc_in, crc_n;
  logic          eq_q, ones_q, grp_q;
  logic          eq_n, ones_n, grp_n, take;
  logic [7:0]    mac_byte;

  always_comb begin
    cur_idx  = da_first ? '0 : idx_q;
    take     = da_valid && (da_first || idx_q != IDLE);
    mac_byte = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (cur_idx == IW'(k)) mac_byte = mac_flat[8*k +: 8];
    crc_in = da_first ? '1 : crc_q;
    crc_n  = crc_step(crc_in, da_byte);
    eq_n   = (da_first || eq_q) && (da_byte == mac_byte);
    ones_n = (da_first || ones_q) && (&da_byte);
    grp_n  = da_first ? da_byte[0] : grp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= IDLE;
      crc_q  <= '1;
      eq_q   <= 1'b0;
      ones_q <= 1'b0;
      grp_q  <= 1'b0;
    end else if (take) begin
      idx_q  <= cur_idx + IW'(1);
      crc_q  <= crc_n;
      eq_q   <= eq_n;
      ones_q <= ones_n;
      grp_q  <= grp_n;
    end
  end

  assign fire    = take && (cur_idx == LAST);
  assign sta_hit = eq_n;
  assign bcast   = ones_n;
  assign grp     = grp_n;
  assign bin     = crc_n[31 -: HASH_BITS];

  // R3: byte position never leaves its range
  p_idx_range_r3: assert property (@(posedge clk) disable iff (rst) idx_q <= IDLE);

  // R3: a first-byte marker always restarts counting
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (da_valid && da_first) |=> (idx_q == IW'(1)));

  // R3: stray bytes after a complete address are not counted
  p_ignore_extra_r3: assert property (@(posedge clk) disable iff (rst)
    (idx_q == IDLE && da_valid && !da_first) |=> (idx_q == IDLE));

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fire,
  input  rxf_mode_t                 mode,
  input  logic [(1<<HASH_BITS)-1:0] hash_flat,
  input  logic                      sta_hit,
  input  logic                      bcast,
  input  logic                      grp,
  input  logic [HASH_BITS-1:0]      bin,
  output logic                      res_valid,
  output logic                      res_accept
);
  logic hash_hit, acc_n;

  always_comb begin
    hash_hit = hash_flat[bin];
    if (mode.promisc)  acc_n = 1'b1;
    else if (sta_hit)  acc_n = 1'b1;
    else if (bcast)    acc_n = mode.bcast;
    else if (grp)      acc_n = mode.all_grp || (mode.hash_grp && hash_hit);
    else               acc_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      res_valid  <= fire;
      res_accept <= fire && acc_n;
    end
  end

  // R1: no result straight out of reset
  p_quiet_reset_r1: assert property (@(posedge clk) rst |=> !res_valid);

  // R3: a result lasts one cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid);

  // R4: promiscuous accepts everything
  p_promisc_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && mode.promisc) |=> (res_valid && res_accept));

  // R5: station match accepts
  p_station_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && sta_hit) |=> res_accept);

  // R6: broadcast with its enable clear is rejected
  p_bcast_off_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && bcast && !sta_hit && !mode.promisc && !mode.bcast) |=> !res_accept);

  // R9: foreign individual address is rejected
  p_foreign_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && !grp && !sta_hit && !mode.promisc) |=> !res_accept);

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int CFG_AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              da_valid,
  input  logic              da_first,
  input  logic [7:0]        da_byte,
  output logic              res_valid,
  output logic              res_accept
);
  localparam int TBL = 1 << HASH_BITS;

  rxf_mode_t                mode;
  logic [8*ADDR_BYTES-1:0]  mac_flat;
  logic [TBL-1:0]           hash_flat;
  logic                     fire, sta_hit, bcast, grp;
  logic [HASH_BITS-1:0]     bin;

  rxf_cfg_regs #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mode(mode), .mac_flat(mac_flat), .hash_flat(hash_flat)
  );

  rxf_addr_track #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_track (
    .clk(clk), .rst(rst), .da_valid(da_valid), .da_first(da_first), .da_byte(da_byte),
    .mac_flat(mac_flat), .fire(fire), .sta_hit(sta_hit), .bcast(bcast), .grp(grp), .bin(bin)
  );

  rxf_decide #(.HASH_BITS(HASH_BITS)) u_decide (
    .clk(clk), .rst(rst), .fire(fire), .mode(mode), .hash_flat(hash_flat),
    .sta_hit(sta_hit), .bcast(bcast), .grp(grp), .bin(bin),
    .res_valid(res_valid), .res_accept(res_accept)
  );

endmodule

// File: tb/rx_da_filter_test.sv
`timescale 1ns/1ps
module rx_da_filter_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic        da_valid = 0, da_first = 0;
  logic [7:0]  da_byte = 0;
  logic        res_valid, res_accept;

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_v = 0, exp_a = 0;
  string cur_req = "R3";

  logic [15:0] m_ctl = 16'h0188;
  logic [7:0]  m_mac [6];
  logic [7:0]  m_hash [8];

  always #4 clk = ~clk;

  rx_da_filter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .da_valid(da_valid), .da_first(da_first), .da_byte(da_byte),
    .res_valid(res_valid), .res_accept(res_accept)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // bitwise CRC over the 48 address bits in arrival order
  function automatic int ref_bin(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[0] ^ da[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return int'(c[31:26]);
  endfunction

  function automatic bit ref_accept(input logic [47:0] da);
    bit is_sta = 1;
    int b;
    for (int k = 0; k < 6; k++) if (da[8*k +: 8] != m_mac[k]) is_sta = 0;
    b = ref_bin(da);
    if (m_ctl[0]) return 1;
    if (is_sta) return 1;
    if (da == 48'hFFFF_FFFF_FFFF) return m_ctl[3];
    if (da[0]) return m_ctl[1] || (m_ctl[4] && m_hash[b >> 3][b & 7]);
    return 0;
  endfunction

  function automatic logic [15:0] ref_reg(input int a);
    if (a == 0) return m_ctl;
    if (a >= 1 && a <= 3) return {m_mac[2*(a-1)+1], m_mac[2*(a-1)]};
    if (a >= 4 && a <= 7) return {m_hash[2*(a-4)+1], m_hash[2*(a-4)]};
    return 16'h0;
  endfunction

  // per-clock comparison of the result outputs against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      checks++;
      if (res_valid !== exp_v || (exp_v && res_accept !== exp_a)) begin
        fails++;
        $display("FAIL %s: valid/accept actual=%0b/%0b expected=%0b/%0b",
                 cur_req, res_valid, res_accept, exp_v, exp_a);
      end
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a == 0) m_ctl = d;
    else if (a >= 1 && a <= 3) begin m_mac[2*(a-1)] = d[7:0]; m_mac[2*(a-1)+1] = d[15:8]; end
    else if (a >= 4 && a <= 7) begin m_hash[2*(a-4)] = d[7:0]; m_hash[2*(a-4)+1] = d[15:8]; end
  endtask

  task automatic rd(input int a, input string req);
    logic [15:0] e;
    @(negedge clk); cfg_addr = 4'(a);
    @(negedge clk);
    e = ref_reg(a);
    checks++;
    if (cfg_rdata !== e) begin
      fails++;
      $display("FAIL %s: read addr %0d actual=%h expected=%h", req, a, cfg_rdata, e);
    end
  endtask

  task automatic send(input logic [47:0] da, input int gap, input string req);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); da_valid = 1; da_first = (k == 0); da_byte = da[8*k +: 8];
      if (k < 5) for (int g = 0; g < gap; g++) begin @(negedge clk); da_valid = 0; da_first = 0; end
    end
    @(negedge clk); da_valid = 0; da_first = 0;
    cur_req = req; exp_a = ref_accept(da); exp_v = 1;
    @(negedge clk); exp_v = 0;
  endtask

  task automatic write_hash();
    for (int j = 0; j < 4; j++) wr(4 + j, {m_hash[2*j+1], m_hash[2*j]});
  endtask

  logic [47:0] sta  = 48'h5544_3322_1102;
  logic [47:0] othr = 48'h0A0B_0C0D_0E10;
  logic [47:0] bc   = 48'hFFFF_FFFF_FFFF;
  logic [47:0] grpa = 48'h0100_005E_0001;

  initial begin
    for (int k = 0; k < 6; k++) m_mac[k] = 0;
    for (int k = 0; k < 8; k++) m_hash[k] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state of every register
    for (int a = 0; a < 8; a++) rd(a, "R1");
    // R2: register layout and read-back
    wr(1, 16'h1102); wr(2, 16'h3322); wr(3, 16'h5544);
    wr(4, 16'hA55A); wr(7, 16'h0F0F);
    for (int a = 1; a < 8; a++) rd(a, "R2");
    wr(9, 16'hFFFF); wr(15, 16'h1234);
    rd(9, "R2"); rd(15, "R2");
    for (int a = 0; a < 8; a++) rd(a, "R2");
    wr(4, 0); wr(7, 0);
    // R5 station accepted with default control; R9 foreign rejected
    send(sta, 0, "R5");
    send(othr, 0, "R9");
    // R6 broadcast with default (bit 3 set) then cleared
    send(bc, 0, "R6");
    wr(0, 16'h0000);
    send(bc, 0, "R6");
    send(sta, 0, "R5");
    send(grpa, 0, "R7");
    // R4 promiscuous
    wr(0, 16'h0001);
    send(othr, 0, "R4"); send(bc, 0, "R4"); send(grpa, 1, "R4");
    // R7 all groups
    wr(0, 16'h0002);
    send(grpa, 0, "R7"); send(othr, 0, "R9"); send(bc, 0, "R6");
    // R8 hash filtering with chosen and random tables
    wr(0, 16'h0010);
    for (int it = 0; it < 24; it++) begin
      logic [47:0] da;
      int b;
      da = {16'($urandom), $urandom};
      da[0] = 1'b1;
      b = ref_bin(da);
      if (it % 3 == 2) for (int j = 0; j < 8; j++) m_hash[j] = 8'($urandom);
      else m_hash[b >> 3][b & 7] = (it % 3 == 0);
      write_hash();
      send(da, it % 2, "R8");
    end
    // R10 unrelated control bits
    wr(0, 16'hFFE4);
    send(bc, 0, "R10"); send(grpa, 0, "R10"); send(othr, 0, "R10"); send(sta, 0, "R10");
    wr(0, 16'hFFEC);
    send(bc, 0, "R10");
    // R3 gaps, restart mid-address, ignored trailing bytes
    wr(0, 16'h0188);
    send(sta, 2, "R3");
    cur_req = "R3";
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); da_valid = 1; da_first = (k == 0); da_byte = othr[8*k +: 8];
    end
    send(sta, 0, "R3");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); da_valid = 1; da_first = 0; da_byte = 8'hFF;
    end
    @(negedge clk); da_valid = 0;
    repeat (3) @(negedge clk);
    send(othr, 0, "R3");
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R3: watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule